// File: doc/BRIEF.md
# Block Floating Point Pass Scaler

This block sits beside the butterfly datapath of a multi-pass fixed-point FFT engine and handles word growth and normalisation between passes. Each butterfly result reaches it as a word one bit wider than the stored sample. The block keeps an 18-bit field of that word. Which field it keeps depends on a growth mode that is latched once per transform. It also finds how many redundant sign bits the largest result of the pass carries.

At the end of each pass the block works out how far every sample must be shifted left before the next pass. That shift is limited per pass and by a budget for the whole transform. The block adds the shift to a running total. The total is shown on a 4-bit scale tag. In the reduced-growth mode a guard-bit mismatch means the sample has overflowed. The block then reserves tag code 15 for that case and raises a zero-force signal, so that downstream logic zeroes every output bin.

Top module: `bfp_pass_scaler`

## Requirements
- R1: A pulse on `start_transform` latches `growth_sel` as the mode for the whole transform (0 = 2-bit growth, 1 = 3-bit growth). It clears the shift total, the overflow flag and `pass_shift` to 0, and marks the next pass as the first.
- R2: One cycle after `res_valid`, `sel_valid` is 1 and `sel_data` holds a field of `res_data`. The field is bits [18:1] in 3-bit mode on every pass after the first. It is bits [17:0] in 2-bit mode and on the first pass. `sel_valid` is 0 in any cycle that does not follow a `res_valid`.
- R3: In 2-bit mode, a result whose bit 18 differs from bit 17 sets overflow from the next cycle. Overflow stays set until the next `start_transform`. In 3-bit mode overflow is never set.
- R4: The extra-sign count of a selected field is the number of leading bits that equal its MSB, minus one (0..17). The pass value is the minimum of this count over the results of the pass. `pass_start` resets the pass value to 17.
- R5: In the cycle after `pass_end`, `pass_shift` equals the smallest of three values: the pass value, 4, and the remaining budget. It holds that value until the next `pass_end` or `start_transform`.
- R6: The shift total grows by `pass_shift` at each `pass_end`. The budget limits the total to 15 in 3-bit mode and to 14 in 2-bit mode.
- R7: `scale_tag` shows the shift total while no overflow is flagged, and shows 15 while overflow is flagged. `zero_force` equals the overflow flag.
- R8: After reset, `sel_valid`, `sel_data`, `pass_shift`, `scale_tag` and `zero_force` are all 0, and the mode is 2-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| growth_sel | input | 1 | Growth mode sampled at transform start (1 = 3-bit) |
| start_transform | input | 1 | Begins a new transform |
| pass_start | input | 1 | Begins a pass |
| pass_end | input | 1 | Ends a pass; the shift is computed |
| res_valid | input | 1 | Butterfly result strobe |
| res_data | input | 19 | Butterfly result, one guard bit above the stored width |
| sel_valid | output | 1 | Selected field is valid |
| sel_data | output | 18 | Selected 18-bit field |
| pass_shift | output | 3 | Left shift to apply before the next pass |
| scale_tag | output | 4 | Total shift, or 15 on overflow |
| zero_force | output | 1 | Forces all output bins to zero |

## Verification
The assertions assume the following about the inputs. `start_transform`, `pass_start`, `pass_end` and `res_valid` are never high in the same cycle as one another. Every result of a pass arrives between that pass's `pass_start` and `pass_end`. `growth_sel` matters only in the cycle of `start_transform`. The stimulus tasks keep to these rules by construction: each task raises one control strobe for exactly one cycle and lowers it before the next task runs. Results are sent one per cycle, strictly inside a pass.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
   typedef enum logic {
      GROW_2B = 1'b0,
      GROW_3B = 1'b1
   } growth_e;
endpackage

// File: rtl/bfp_field_sel.sv
module bfp_field_sel #(
   parameter int DATA_W = 18,
   localparam int WIDE_W = DATA_W + 1
) (
   input  logic [WIDE_W-1:0] wide,
   input  logic              use_top,
   output logic [DATA_W-1:0] field,
   output logic              guard_bad
);
   // Upper field keeps the top DATA_W bits; lower field drops the guard bit.
   assign field     = use_top ? wide[WIDE_W-1 -: DATA_W] : wide[DATA_W-1:0];
   // In the lower field the guard bit must copy the field's sign bit.
   assign guard_bad = wide[WIDE_W-1] ^ wide[WIDE_W-2];
endmodule

// File: rtl/bfp_lead_sign.sv
module bfp_lead_sign #(
   parameter int W = 18,
   localparam int CNT_W = $clog2(W)
) (
   input  logic [W-1:0]     v,
   output logic [CNT_W-1:0] extra
);
   logic [W-2:0] run;

   generate
      for (genvar i = W - 2; i >= 0; i--) begin : g_run
         if (i == W - 2) begin : g_head
            assign run[i] = (v[i] == v[W-1]);
         end else begin : g_chain
            assign run[i] = run[i+1] & (v[i] == v[W-1]);
         end
      end
   endgenerate

   always_comb begin
      extra = '0;
      for (int i = 0; i < W - 1; i++) begin
         extra = extra + CNT_W'(run[i]);
      end
   end
endmodule

// File: rtl/bfp_shift_ctrl.sv
module bfp_shift_ctrl #(
   parameter int DATA_W    = 18,
   parameter int MAX_SHIFT = 4,
   parameter int TAG_W     = 4,
   localparam int CNT_W    = $clog2(DATA_W),
   localparam int SHIFT_W  = $clog2(MAX_SHIFT + 1),
   localparam int CW       = ((CNT_W > TAG_W) ? CNT_W : TAG_W) + 1,
   localparam int TAG_MAX  = (1 << TAG_W) - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               pass_start,
   input  logic               pass_end,
   input  logic               sample_valid,
   input  logic [CNT_W-1:0]   sample_cnt,
   input  logic               mode3,
   output logic               first_pass,
   output logic [TAG_W-1:0]   total,
   output logic [SHIFT_W-1:0] pass_shift
);
   logic [CNT_W-1:0]   min_q;
   logic [CW-1:0]      cap, room, want;
   logic [SHIFT_W-1:0] shift_nxt;

   always_comb begin
      cap  = mode3 ? CW'(TAG_MAX) : CW'(TAG_MAX - 1);
      room = cap - CW'(total);
      want = CW'(min_q);
      if (want > CW'(MAX_SHIFT)) want = CW'(MAX_SHIFT);
      if (want > room)           want = room;
      shift_nxt = want[SHIFT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         min_q      <= CNT_W'(DATA_W - 1);
         total      <= '0;
         pass_shift <= '0;
         first_pass <= 1'b1;
      end else if (start) begin
         min_q      <= CNT_W'(DATA_W - 1);
         total      <= '0;
         pass_shift <= '0;
         first_pass <= 1'b1;
      end else if (pass_start) begin
         min_q <= CNT_W'(DATA_W - 1);
      end else if (pass_end) begin
         pass_shift <= shift_nxt;
         total      <= total + TAG_W'(shift_nxt);
         first_pass <= 1'b0;
      end else if (sample_valid && (sample_cnt < min_q)) begin
         min_q <= sample_cnt;
      end
   end
endmodule

// File: rtl/bfp_pass_scaler.sv
module bfp_pass_scaler #(
   parameter int DATA_W    = 18,
   parameter int MAX_SHIFT = 4,
   parameter int TAG_W     = 4,
   localparam int WIDE_W   = DATA_W + 1,
   localparam int CNT_W    = $clog2(DATA_W),
   localparam int SHIFT_W  = $clog2(MAX_SHIFT + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               growth_sel,
   input  logic               start_transform,
   input  logic               pass_start,
   input  logic               pass_end,
   input  logic               res_valid,
   input  logic [WIDE_W-1:0]  res_data,
   output logic               sel_valid,
   output logic [DATA_W-1:0]  sel_data,
   output logic [SHIFT_W-1:0] pass_shift,
   output logic [TAG_W-1:0]   scale_tag,
   output logic               zero_force
);
   import bfp_pkg::*;

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("DATA_W must be at least 4");
      end
      if (MAX_SHIFT < 1 || MAX_SHIFT >= DATA_W) begin : g_bad_shift
         $error("MAX_SHIFT must lie in 1..DATA_W-1");
      end
      if (TAG_W < 2) begin : g_bad_tag
         $error("TAG_W must be at least 2");
      end
   endgenerate

   growth_e             mode_q;
   logic                ovf_q;
   logic                first_pass;
   logic                use_top;
   logic [DATA_W-1:0]   field;
   logic                guard_bad;
   logic [CNT_W-1:0]    extra;
   logic [TAG_W-1:0]    total;

   assign use_top = (mode_q == GROW_3B) && !first_pass;

   bfp_field_sel #(.DATA_W(DATA_W)) u_sel (
      .wide      (res_data),
      .use_top   (use_top),
      .field     (field),
      .guard_bad (guard_bad)
   );

   bfp_lead_sign #(.W(DATA_W)) u_lead (
      .v     (field),
      .extra (extra)
   );

   bfp_shift_ctrl #(
      .DATA_W    (DATA_W),
      .MAX_SHIFT (MAX_SHIFT),
      .TAG_W     (TAG_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start_transform),
      .pass_start   (pass_start),
      .pass_end     (pass_end),
      .sample_valid (res_valid),
      .sample_cnt   (extra),
      .mode3        (mode_q == GROW_3B),
      .first_pass   (first_pass),
      .total        (total),
      .pass_shift   (pass_shift)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= GROW_2B;
         ovf_q  <= 1'b0;
      end else if (start_transform) begin
         mode_q <= growth_e'(growth_sel);
         ovf_q  <= 1'b0;
      end else if (res_valid && (mode_q == GROW_2B) && guard_bad) begin
         ovf_q  <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_valid <= 1'b0;
         sel_data  <= '0;
      end else begin
         sel_valid <= res_valid;
         if (res_valid) sel_data <= field;
      end
   end

   assign scale_tag  = ovf_q ? '1 : total;
   assign zero_force = ovf_q;
endmodule

// File: rtl/bfp_pass_scaler_chk.sv
module bfp_pass_scaler_chk #(
   parameter int DATA_W    = 18,
   parameter int MAX_SHIFT = 4,
   parameter int TAG_W     = 4,
   localparam int WIDE_W   = DATA_W + 1,
   localparam int SHIFT_W  = $clog2(MAX_SHIFT + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_transform,
   input logic               pass_end,
   input logic               res_valid,
   input logic [WIDE_W-1:0]  res_data,
   input logic               sel_valid,
   input logic [SHIFT_W-1:0] pass_shift,
   input logic [TAG_W-1:0]   scale_tag,
   input logic               zero_force,
   input logic               mode3
);
   a_r2_sel_follows: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> sel_valid);
   a_r2_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |=> !sel_valid);
   a_r3_ovf_detect: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !mode3 && !start_transform &&
       (res_data[WIDE_W-1] != res_data[WIDE_W-2])) |=> zero_force);
   a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_force && !start_transform) |=> zero_force);
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (mode3 && !zero_force && !start_transform) |=> !zero_force);
   a_r5_shift_limit: assert property (@(posedge clk) disable iff (!rst_n)
      pass_shift <= SHIFT_W'(MAX_SHIFT));
   a_r5_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!pass_end && !start_transform) |=> $stable(pass_shift));
   a_r6_tag_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (!zero_force && !mode3) |-> (scale_tag != '1));
   a_r7_tag_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      zero_force |-> (scale_tag == '1));
   a_r7_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!pass_end && !start_transform && !res_valid) |=> $stable(scale_tag));
endmodule

bind bfp_pass_scaler bfp_pass_scaler_chk #(
   .DATA_W    (DATA_W),
   .MAX_SHIFT (MAX_SHIFT),
   .TAG_W     (TAG_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .start_transform (start_transform),
   .pass_end        (pass_end),
   .res_valid       (res_valid),
   .res_data        (res_data),
   .sel_valid       (sel_valid),
   .pass_shift      (pass_shift),
   .scale_tag       (scale_tag),
   .zero_force      (zero_force),
   .mode3           (mode_q == bfp_pkg::GROW_3B)
);

// File: tb/bfp_pass_scaler_tb.sv
module bfp_pass_scaler_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        growth_sel = 1'b0;
   logic        start_transform = 1'b0;
   logic        pass_start = 1'b0;
   logic        pass_end = 1'b0;
   logic        res_valid = 1'b0;
   logic [18:0] res_data = '0;
   logic        sel_valid;
   logic [17:0] sel_data;
   logic [2:0]  pass_shift;
   logic [3:0]  scale_tag;
   logic        zero_force;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [17:0] exp_q[$];
   bit m3, first, ovf;
   int emin, etotal, eshift;

   always #5 clk = ~clk;

   bfp_pass_scaler u_dut (
      .clk(clk), .rst_n(rst_n), .growth_sel(growth_sel),
      .start_transform(start_transform), .pass_start(pass_start),
      .pass_end(pass_end), .res_valid(res_valid), .res_data(res_data),
      .sel_valid(sel_valid), .sel_data(sel_data), .pass_shift(pass_shift),
      .scale_tag(scale_tag), .zero_force(zero_force)
   );

   task automatic chk(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   function automatic int sign_extra(logic [17:0] v);
      logic [17:0] m;
      int n;
      m = v[17] ? ~v : v;
      n = 0;
      while (n < 18 && m[17-n] == 1'b0) n++;
      return n - 1;
   endfunction

   function automatic logic [18:0] mk_low(logic [17:0] f);
      return {f[17], f};
   endfunction

   // Scoreboard monitor (R2)
   always @(negedge clk) begin
      if (rst_n && sel_valid) begin
         if (exp_q.size() == 0) begin
            chk("R2 unexpected sel_valid", 1, 0);
         end else begin
            logic [17:0] e;
            e = exp_q.pop_front();
            chk("R2 sel_data", int'(sel_data), int'(e));
         end
      end
   end

   task automatic start_tf(bit mode);
      growth_sel = mode;
      @(posedge clk); #1 start_transform = 1'b1;
      @(posedge clk); #1 start_transform = 1'b0; growth_sel = ~mode;
      m3 = mode; first = 1'b1; ovf = 1'b0; etotal = 0; eshift = 0;
      @(negedge clk);
      chk("R1 tag cleared", int'(scale_tag), 0);
      chk("R1 zero_force cleared", int'(zero_force), 0);
      chk("R1 pass_shift cleared", int'(pass_shift), 0);
   endtask

   task automatic begin_pass();
      @(posedge clk); #1 pass_start = 1'b1;
      @(posedge clk); #1 pass_start = 1'b0;
      emin = 17;
   endtask

   task automatic send(logic [18:0] w);
      logic [17:0] f;
      int x;
      f = (m3 && !first) ? w[18:1] : w[17:0];
      exp_q.push_back(f);
      x = sign_extra(f);
      if (x < emin) emin = x;
      if (!m3 && (w[18] != w[17])) ovf = 1'b1;
      @(posedge clk); #1 res_valid = 1'b1; res_data = w;
      @(posedge clk); #1 res_valid = 1'b0; res_data = '0;
   endtask

   task automatic end_pass(string tag);
      int cap, s;
      cap = m3 ? 15 : 14;
      s = emin;
      if (s > 4) s = 4;
      if (s > cap - etotal) s = cap - etotal;
      eshift = s; etotal = etotal + s; first = 1'b0;
      @(posedge clk); #1 pass_end = 1'b1;
      @(posedge clk); #1 pass_end = 1'b0;
      @(negedge clk);
      chk({"R5 pass_shift ", tag}, int'(pass_shift), eshift);
      chk({"R6/R7 scale_tag ", tag}, int'(scale_tag), ovf ? 15 : etotal);
      chk({"R3 zero_force ", tag}, int'(zero_force), int'(ovf));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R8 sel_valid", int'(sel_valid), 0);
      chk("R8 sel_data", int'(sel_data), 0);
      chk("R8 pass_shift", int'(pass_shift), 0);
      chk("R8 scale_tag", int'(scale_tag), 0);
      chk("R8 zero_force", int'(zero_force), 0);
      #1 rst_n = 1'b1;

      // 3-bit mode: first pass lower field, later passes upper field
      start_tf(1'b1);
      begin_pass(); send(19'd100); send(-19'sd300); end_pass("3b p1");
      // guard mismatch must not flag overflow in 3-bit mode (R3)
      begin_pass(); send(19'd50); send(19'h20000); end_pass("3b p2 R3");
      begin_pass(); send(19'd20); end_pass("3b p3");
      begin_pass(); send(19'd8); end_pass("3b p4");
      begin_pass(); end_pass("3b p5 cap15 R6");
      begin_pass(); end_pass("3b p6 budget spent");

      // 2-bit mode: empty passes reach cap 14
      start_tf(1'b0);
      for (int p = 0; p < 5; p++) begin
         begin_pass(); end_pass("2b cap14 R6");
      end

      // minimum over mixed samples (R4), then overflow (R3/R7)
      start_tf(1'b0);
      begin_pass();
      send(mk_low(18'h00FFF)); send(mk_low(18'h03000));
      send(mk_low(18'h38000)); send(mk_low(18'h3FFFF));
      end_pass("R4 min");
      begin_pass(); send(mk_low(18'h00010)); send(19'h40000);
      end_pass("R3 ovf set");
      begin_pass(); send(19'd4); end_pass("R3 ovf sticky");

      // restart clears overflow; R2 field choice in 3-bit after first pass
      start_tf(1'b1);
      begin_pass(); send(19'h1FFFF); end_pass("R1 restart p1");
      begin_pass(); send(19'h2A5A5); send(19'h7FFFF); end_pass("R1 restart p2");

      repeat (3) @(negedge clk);
      chk("R2 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule